// File: doc/BRIEF.md
# Early Branch Target Checker

This block sits at the exit of an instruction decode stage and examines a group of up to `W` instructions each cycle, ordered oldest first by slot. For every live slot it looks at the predicted-taken flag, the predicted target, the class flags (control, direct, unconditional) and the target that decode computed. Two mistakes are caught. The first is an instruction that was predicted taken but is not a control instruction. The second is a direct unconditional branch whose computed target differs from its predicted target.

When the oldest mistaken slot is found, the block sends one redirect toward fetch. The redirect carries the offending sequence number, its thread, the computed target as the next fetch address, and a taken flag. The offending instruction is still forwarded downstream, with its predicted target corrected. Slots younger than it are held back from emission. Slots after it that belong to the same thread and carry a newer sequence number are flagged as killed. Instructions of other threads are never killed. Three counters track resolved branches, target mispredictions and non-control mispredictions.

All results are registered and appear one clock edge after the group is presented.

Top module: `early_target_check`

## Requirements
- R1: While reset is asserted, and on the first edge after it, all emit and kill bits, the redirect outputs and all three counters are zero.
- R2: A slot with its valid bit low or its squashed bit high is never emitted, never killed and never raises a redirect, even if its flags describe a misprediction.
- R3: One edge after a group with no mistaken slot, every live slot is emitted, no slot is killed and `redir_valid` is low.
- R4: `cnt_resolved` grows by the number of emitted slots that are control, direct and unconditional, including an emitted offender. Arithmetic is modulo 2^CNT_W.
- R5: A live direct unconditional control slot whose computed target differs from its predicted target raises a redirect with `redir_taken`=1 and `redir_ctrl_err`=0, and increments `cnt_mispred` by one.
- R6: A live slot predicted taken that is not a control instruction raises a redirect with `redir_taken`=0 and `redir_ctrl_err`=1, and increments `cnt_ctrl_err` by one.
- R7: The offending slot is emitted, together with every live slot before it. No slot after it is emitted in that cycle.
- R8: A live slot after the offender is flagged in `out_kill` only if its thread equals the offender's thread and its sequence number is newer. Emit and kill bits never overlap.
- R9: When several slots are mistaken, only the lowest-numbered one raises the redirect. `redir_seq`, `redir_tid` and `redir_pc` carry that slot's sequence number, thread and computed target.
- R10: For an emitted slot with a target mismatch, `out_pred_tgt` carries the computed target. Every other emitted slot passes its predicted target through unchanged.
- R11: Sequence number `a` is newer than `b` when (a-b) mod 2^SEQ_W lies in 1 to 2^(SEQ_W-1)-1. The comparison therefore holds across the wrap from all ones to zero.
- R12: Conditional branches and indirect branches are not resolved. A target mismatch on them raises no redirect and leaves `cnt_resolved` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | W | Slot holds an instruction |
| in_squashed | input | W | Slot was already squashed upstream |
| in_tid | input | W*TID_W | Thread of each slot |
| in_seq | input | W*SEQ_W | Sequence number of each slot |
| in_pred_taken | input | W | Predicted-taken flag |
| in_pred_tgt | input | W*PC_W | Predicted target |
| in_is_ctrl | input | W | Control instruction class |
| in_is_direct | input | W | Direct (PC-relative) target |
| in_is_uncond | input | W | Unconditional control |
| in_calc_tgt | input | W*PC_W | Target computed in decode |
| out_emit | output | W | Slot forwarded downstream |
| out_kill | output | W | Slot marked squashed |
| out_pred_tgt | output | W*PC_W | Predicted target after correction |
| redir_valid | output | 1 | Redirect to fetch |
| redir_tid | output | TID_W | Thread of the redirect |
| redir_seq | output | SEQ_W | Offending sequence number |
| redir_pc | output | PC_W | Next fetch address |
| redir_taken | output | 1 | Redirect follows a taken branch |
| redir_ctrl_err | output | 1 | Cause was a non-control predicted taken |
| cnt_resolved | output | CNT_W | Branches resolved here |
| cnt_mispred | output | CNT_W | Target mispredictions |
| cnt_ctrl_err | output | CNT_W | Non-control predicted-taken events |

## Verification
Every output of this block is due exactly one rising edge after the group is applied. This covers the emit and kill masks, the corrected targets, the redirect fields and the updated counters. The counters move on the same edge as the redirect they account for.

The bench drives each group on a falling edge and samples on the next falling edge, which is one full register stage later and half a period clear of any edge. It then applies the next group in that same half cycle.

Reset is checked asynchronously, a short delay after `rst_n` falls, with no clock edge required.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  // Why a slot stops the group
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_NOT_CTRL = 2'd1,
    CAUSE_TARGET   = 2'd2
  } cause_e;
endpackage

// File: rtl/ebc_slot_eval.sv
module ebc_slot_eval
  import ebc_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            live,
  input  logic            pred_taken,
  input  logic            is_ctrl,
  input  logic            is_direct,
  input  logic            is_uncond,
  input  logic [PC_W-1:0] pred_tgt,
  input  logic [PC_W-1:0] calc_tgt,
  output cause_e          cause,
  output logic            resolves
);
  function automatic logic target_differs(input logic [PC_W-1:0] a, input logic [PC_W-1:0] b);
    return a != b;
  endfunction

  always_comb begin
    resolves = live & is_ctrl & is_direct & is_uncond;
    cause    = CAUSE_NONE;
    if (live && pred_taken && !is_ctrl)
      cause = CAUSE_NOT_CTRL;
    else if (resolves && target_differs(calc_tgt, pred_tgt))
      cause = CAUSE_TARGET;
  end
endmodule

// File: rtl/ebc_first_pick.sv
module ebc_first_pick #(
  parameter int W = 4
) (
  input  logic [W-1:0] bad,
  output logic [W-1:0] first_oh,
  output logic [W-1:0] upto,
  output logic         any_bad
);
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < W; i++) begin
      upto[i]     = !seen;
      first_oh[i] = bad[i] & !seen;
      seen        = seen | bad[i];
    end
    any_bad = seen;
  end
endmodule

// File: rtl/ebc_kill_mask.sv
module ebc_kill_mask #(
  parameter int W     = 4,
  parameter int SEQ_W = 8,
  parameter int TID_W = 1
) (
  input  logic [W-1:0]       live,
  input  logic [W-1:0]       after,
  input  logic [W*SEQ_W-1:0] seqs,
  input  logic [W*TID_W-1:0] tids,
  input  logic [SEQ_W-1:0]   off_seq,
  input  logic [TID_W-1:0]   off_tid,
  output logic [W-1:0]       kill
);
  // a is newer than b when the modular distance is positive and under half range
  function automatic logic seq_newer(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return (d != '0) && !d[SEQ_W-1];
  endfunction

  always_comb begin
    for (int i = 0; i < W; i++) begin
      kill[i] = live[i] & after[i]
              & (tids[i*TID_W +: TID_W] == off_tid)
              & seq_newer(seqs[i*SEQ_W +: SEQ_W], off_seq);
    end
  end
endmodule

// File: rtl/early_target_check.sv
module early_target_check
  import ebc_pkg::*;
#(
  parameter int W     = 4,
  parameter int SEQ_W = 8,
  parameter int PC_W  = 16,
  parameter int TID_W = 1,
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [W-1:0]       in_valid,
  input  logic [W-1:0]       in_squashed,
  input  logic [W*TID_W-1:0] in_tid,
  input  logic [W*SEQ_W-1:0] in_seq,
  input  logic [W-1:0]       in_pred_taken,
  input  logic [W*PC_W-1:0]  in_pred_tgt,
  input  logic [W-1:0]       in_is_ctrl,
  input  logic [W-1:0]       in_is_direct,
  input  logic [W-1:0]       in_is_uncond,
  input  logic [W*PC_W-1:0]  in_calc_tgt,
  output logic [W-1:0]       out_emit,
  output logic [W-1:0]       out_kill,
  output logic [W*PC_W-1:0]  out_pred_tgt,
  output logic               redir_valid,
  output logic [TID_W-1:0]   redir_tid,
  output logic [SEQ_W-1:0]   redir_seq,
  output logic [PC_W-1:0]    redir_pc,
  output logic               redir_taken,
  output logic               redir_ctrl_err,
  output logic [CNT_W-1:0]   cnt_resolved,
  output logic [CNT_W-1:0]   cnt_mispred,
  output logic [CNT_W-1:0]   cnt_ctrl_err
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]        live, resolves, bad, first_oh, upto, after, kill_n, emit_n;
  cause_e              cause [W];
  logic [SEQ_W-1:0]    off_seq;
  logic [TID_W-1:0]    off_tid;
  logic [PC_W-1:0]     off_pc;
  cause_e              off_cause;
  logic                any_bad;
  logic [W*PC_W-1:0]   ptgt_n;

  function automatic logic [CW-1:0] count_set(input logic [W-1:0] m);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < W; i++) n = n + CW'(m[i]);
    return n;
  endfunction

  assign live = in_valid & ~in_squashed;

  generate
    for (genvar g = 0; g < W; g++) begin : g_slot
      ebc_slot_eval #(.PC_W(PC_W)) u_eval (
        .live      (live[g]),
        .pred_taken(in_pred_taken[g]),
        .is_ctrl   (in_is_ctrl[g]),
        .is_direct (in_is_direct[g]),
        .is_uncond (in_is_uncond[g]),
        .pred_tgt  (in_pred_tgt[g*PC_W +: PC_W]),
        .calc_tgt  (in_calc_tgt[g*PC_W +: PC_W]),
        .cause     (cause[g]),
        .resolves  (resolves[g])
      );
      assign bad[g] = (cause[g] != CAUSE_NONE);
    end
  endgenerate

  ebc_first_pick #(.W(W)) u_pick (
    .bad     (bad),
    .first_oh(first_oh),
    .upto    (upto),
    .any_bad (any_bad)
  );

  assign emit_n = live & upto;
  assign after  = ~upto;

  always_comb begin
    off_seq   = '0;
    off_tid   = '0;
    off_pc    = '0;
    off_cause = CAUSE_NONE;
    for (int i = 0; i < W; i++) begin
      if (first_oh[i]) begin
        off_seq   = in_seq[i*SEQ_W +: SEQ_W];
        off_tid   = in_tid[i*TID_W +: TID_W];
        off_pc    = in_calc_tgt[i*PC_W +: PC_W];
        off_cause = cause[i];
      end
    end
  end

  ebc_kill_mask #(.W(W), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_kill (
    .live   (live),
    .after  (after),
    .seqs   (in_seq),
    .tids   (in_tid),
    .off_seq(off_seq),
    .off_tid(off_tid),
    .kill   (kill_n)
  );

  always_comb begin
    for (int i = 0; i < W; i++) begin
      ptgt_n[i*PC_W +: PC_W] = (emit_n[i] && cause[i] == CAUSE_TARGET)
                             ? in_calc_tgt[i*PC_W +: PC_W]
                             : in_pred_tgt[i*PC_W +: PC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_emit       <= '0;
      out_kill       <= '0;
      out_pred_tgt   <= '0;
      redir_valid    <= 1'b0;
      redir_tid      <= '0;
      redir_seq      <= '0;
      redir_pc       <= '0;
      redir_taken    <= 1'b0;
      redir_ctrl_err <= 1'b0;
      cnt_resolved   <= '0;
      cnt_mispred    <= '0;
      cnt_ctrl_err   <= '0;
    end else begin
      out_emit       <= emit_n;
      out_kill       <= kill_n;
      out_pred_tgt   <= ptgt_n;
      redir_valid    <= any_bad;
      redir_tid      <= off_tid;
      redir_seq      <= off_seq;
      redir_pc       <= off_pc;
      redir_taken    <= (off_cause == CAUSE_TARGET);
      redir_ctrl_err <= (off_cause == CAUSE_NOT_CTRL);
      cnt_resolved   <= cnt_resolved + CNT_W'(count_set(resolves & emit_n));
      cnt_mispred    <= cnt_mispred + CNT_W'(off_cause == CAUSE_TARGET);
      cnt_ctrl_err   <= cnt_ctrl_err + CNT_W'(off_cause == CAUSE_NOT_CTRL);
    end
  end

  AST_EMIT_KILL_APART: assert property (@(posedge clk) disable iff (!rst_n)
    (out_emit & out_kill) == '0);                                                  // R8
  AST_KILL_NEEDS_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_kill) |-> redir_valid);                                                  // R8
  AST_REDIR_HAS_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (|out_emit));                                                  // R7
  AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(first_oh));                                                           // R9
  AST_MISPRED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && redir_taken) |-> cnt_mispred == CNT_W'($past(cnt_mispred) + 1'b1));   // R5
  AST_CTRL_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && redir_ctrl_err) |-> cnt_ctrl_err == CNT_W'($past(cnt_ctrl_err) + 1'b1)); // R6
endmodule

// File: tb/tb_early_target_check.sv
`timescale 1ns/1ps
module tb_early_target_check;
  localparam int W = 4, SEQ_W = 8, PC_W = 16, TID_W = 1, CNT_W = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [W-1:0]       in_valid, in_squashed, in_pred_taken, in_is_ctrl, in_is_direct, in_is_uncond;
  logic [W*TID_W-1:0] in_tid;
  logic [W*SEQ_W-1:0] in_seq;
  logic [W*PC_W-1:0]  in_pred_tgt, in_calc_tgt;
  logic [W-1:0]       out_emit, out_kill;
  logic [W*PC_W-1:0]  out_pred_tgt;
  logic               redir_valid, redir_taken, redir_ctrl_err;
  logic [TID_W-1:0]   redir_tid;
  logic [SEQ_W-1:0]   redir_seq;
  logic [PC_W-1:0]    redir_pc;
  logic [CNT_W-1:0]   cnt_resolved, cnt_mispred, cnt_ctrl_err;

  always #2 clk = ~clk;

  early_target_check #(.W(W), .SEQ_W(SEQ_W), .PC_W(PC_W), .TID_W(TID_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_squashed(in_squashed), .in_tid(in_tid),
    .in_seq(in_seq), .in_pred_taken(in_pred_taken), .in_pred_tgt(in_pred_tgt),
    .in_is_ctrl(in_is_ctrl), .in_is_direct(in_is_direct), .in_is_uncond(in_is_uncond),
    .in_calc_tgt(in_calc_tgt), .out_emit(out_emit), .out_kill(out_kill),
    .out_pred_tgt(out_pred_tgt), .redir_valid(redir_valid), .redir_tid(redir_tid),
    .redir_seq(redir_seq), .redir_pc(redir_pc), .redir_taken(redir_taken),
    .redir_ctrl_err(redir_ctrl_err), .cnt_resolved(cnt_resolved), .cnt_mispred(cnt_mispred),
    .cnt_ctrl_err(cnt_ctrl_err));

  // Slot kinds: 0 empty, 1 plain t0, 2 direct-uncond ok, 3 direct-uncond wrong target,
  // 4 non-control predicted taken, 5 conditional wrong target, 6 squashed wrong-target,
  // 7 plain t1, 8 direct-uncond wrong target t1, 9 indirect uncond wrong target.
  // Vector: base seq, kinds (slot0 = low nibble), emit, kill, offender slot (7 none), taken, resolved delta
  localparam int NV = 10;
  localparam logic [38:0] VEC [NV] = '{
    {8'd10,  16'h1111, 4'b1111, 4'b0000, 3'd7, 1'b0, 3'd0},  // R3 clean group
    {8'd14,  16'h1122, 4'b1111, 4'b0000, 3'd7, 1'b0, 3'd2},  // R4 correct resolves
    {8'd18,  16'h1131, 4'b0011, 4'b1100, 3'd1, 1'b1, 3'd1},  // R5 R7 R8 R10
    {8'd22,  16'h1412, 4'b0111, 4'b1000, 3'd2, 1'b0, 3'd1},  // R6
    {8'd26,  16'h3141, 4'b0011, 4'b1100, 3'd1, 1'b0, 3'd0},  // R9 two offenders
    {8'd30,  16'h7173, 4'b0001, 4'b0100, 3'd0, 1'b1, 3'd1},  // R8 other thread kept
    {8'd34,  16'h0106, 4'b0100, 4'b0000, 3'd7, 1'b0, 3'd0},  // R2 squashed and empty
    {8'd38,  16'h1195, 4'b1111, 4'b0000, 3'd7, 1'b0, 3'd0},  // R12 cond and indirect
    {8'd42,  16'h7187, 4'b0011, 4'b1000, 3'd1, 1'b1, 3'd1},  // R9 thread-1 offender
    {8'hFE,  16'h1131, 4'b0011, 4'b1100, 3'd1, 1'b1, 3'd1}   // R11 wrap
  };

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [3:0]       cur_kind [W];
  logic [SEQ_W-1:0] cur_seq  [W];
  logic [PC_W-1:0]  cur_pred [W];
  logic [PC_W-1:0]  cur_calc [W];
  logic [CNT_W-1:0] e_res = '0, e_mis = '0, e_ctl = '0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic set_slot(input int i, input logic [3:0] k, input logic [SEQ_W-1:0] s);
    logic wrong;
    wrong = (k == 3 || k == 4 || k == 5 || k == 6 || k == 8 || k == 9);
    cur_kind[i] = k;
    cur_seq[i]  = s;
    cur_pred[i] = 16'h1000 + PC_W'(i * 16);
    cur_calc[i] = cur_pred[i] + (wrong ? 16'h0040 : 16'h0000);
    in_valid[i]      = (k != 0);
    in_squashed[i]   = (k == 6);
    in_tid[i]        = (k == 7 || k == 8);
    in_pred_taken[i] = !(k == 0 || k == 1 || k == 7);
    in_is_ctrl[i]    = (k == 2 || k == 3 || k == 5 || k == 6 || k == 8 || k == 9);
    in_is_direct[i]  = (k == 2 || k == 3 || k == 5 || k == 6 || k == 8);
    in_is_uncond[i]  = (k == 2 || k == 3 || k == 6 || k == 8 || k == 9);
    in_seq[i*SEQ_W +: SEQ_W]     = s;
    in_pred_tgt[i*PC_W +: PC_W]  = cur_pred[i];
    in_calc_tgt[i*PC_W +: PC_W]  = cur_calc[i];
  endtask

  task automatic apply(input logic [7:0] base, input logic [15:0] kinds);
    for (int i = 0; i < W; i++) set_slot(i, kinds[4*i +: 4], base + SEQ_W'(i));
  endtask

  task automatic expect_out(input logic [3:0] emit, input logic [3:0] kill, input logic [2:0] ks,
                            input logic taken, input logic [2:0] dres);
    chk("R7", "emit", 32'(out_emit), 32'(emit));
    chk("R8", "kill", 32'(out_kill), 32'(kill));
    chk("R9", "redir_valid", 32'(redir_valid), 32'(ks != 3'd7));
    if (ks != 3'd7) begin
      chk("R9", "redir_seq", 32'(redir_seq), 32'(cur_seq[ks]));
      chk("R9", "redir_tid", 32'(redir_tid), 32'(cur_kind[ks] == 8));
      chk("R9", "redir_pc", 32'(redir_pc), 32'(cur_calc[ks]));
      chk(taken ? "R5" : "R6", "redir_taken", 32'(redir_taken), 32'(taken));
      chk(taken ? "R5" : "R6", "redir_ctrl_err", 32'(redir_ctrl_err), 32'(!taken));
      if (taken) e_mis++; else e_ctl++;
    end
    for (int i = 0; i < W; i++)
      if (emit[i])
        chk("R10", "pred_tgt", 32'(out_pred_tgt[i*PC_W +: PC_W]),
            32'((i == int'(ks) && (cur_kind[i] == 3 || cur_kind[i] == 8)) ? cur_calc[i] : cur_pred[i]));
    e_res = e_res + CNT_W'(dres);
    chk("R4", "cnt_resolved", 32'(cnt_resolved), 32'(e_res));
    chk("R5", "cnt_mispred", 32'(cnt_mispred), 32'(e_mis));
    chk("R6", "cnt_ctrl_err", 32'(cnt_ctrl_err), 32'(e_ctl));
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    apply(8'd0, 16'h0000);
    repeat (2) @(negedge clk);
    chk("R1", "emit in reset", 32'(out_emit), 0);
    chk("R1", "redir in reset", 32'(redir_valid), 0);
    chk("R1", "counters in reset", 32'({cnt_resolved, cnt_mispred, cnt_ctrl_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "emit after reset", 32'(out_emit), 0);

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][38:31], VEC[v][30:15]);
      @(negedge clk);
      expect_out(VEC[v][14:11], VEC[v][10:7], VEC[v][6:4], VEC[v][3], VEC[v][2:0]);
    end

    // R11 R8: same-thread slots after the offender with older seq numbers are kept
    apply(8'd20, 16'h1131);
    set_slot(2, 4'd1, 8'd21 + 8'd200);
    set_slot(3, 4'd1, 8'd15);
    @(negedge clk);
    expect_out(4'b0011, 4'b0000, 3'd1, 1'b1, 3'd1);

    // R3 R2: idle group emits nothing and raises nothing
    apply(8'd0, 16'h0000);
    @(negedge clk);
    expect_out(4'b0000, 4'b0000, 3'd7, 1'b0, 3'd0);

    // R1: reset in the middle of traffic clears everything at once
    apply(8'd50, 16'h1131);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "emit on reset", 32'(out_emit), 0);
    chk("R1", "redir on reset", 32'(redir_valid), 0);
    chk("R1", "counters on reset", 32'({cnt_resolved, cnt_mispred, cnt_ctrl_err}), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule